// File: doc/BRIEF.md
# Activity-Tracking Slave Polling Scheduler

This block sits on the master side of a command-response bus, where only the master may start a transfer. It decides which slave is polled in each slot of a cycle frame. For every slave it keeps a status bit and a 7-bit count of consecutive idle (dummy) responses. A slave whose count grows past a programmable threshold leaves the active list, and later frames skip it.

A frame starts on a pulse. The block polls the slaves on the active list, as they stood at the frame start, in ascending ID order. Each slot is held until a response strobe arrives. After the normal part, one revive slot polls a single dropped slave, chosen round-robin, so that the slave can rejoin. A dropped slave cannot ask to be polled, so it waits for its turn. A one-cycle done pulse closes the frame. Moving the packets themselves is left to the surrounding bus logic.

Top module: `poll_sched`

## Requirements
- R1: After reset every slave is on the active list with a cleared idle count and status bit 1. No slot is offered (`poll_valid_o`=0) and `frame_done_o` is 0.
- R2: A response is active when bit 7 of `ack_status_i` is 1 and dummy when it is 0; bits 6:0 are ignored. An active response clears the slave's idle count and sets its `status_o` bit. A dummy response clears the status bit and adds one to the count, which saturates at 127.
- R3: When a dummy response brings a slave's count strictly above `thresh_i` (usable range 1..128), the slave leaves the active list from the next frame on. With `thresh_i`=128 no slave is ever dropped.
- R4: In the normal part of a frame, exactly the slaves on the active list at the frame start are polled, one slot each, in ascending ID order. `poll_revive_o`=0 in these slots. Each slot holds `poll_id_o` until `rsp_valid_i` is 1 at a clock edge.
- R5: After the normal part, if any slave was off the list at the frame start, exactly one revive slot (`poll_revive_o`=1) polls one of them. The candidates are searched upward, with wrap-around, starting after the slave revived last. After reset the search starts at ID 0.
- R6: If no slave was off the list at the frame start, the frame has no revive slot.
- R7: A revived slave that gives an active response is back on the active list for the next frame. A dummy response keeps it off the list.
- R8: `frame_done_o` is a one-cycle pulse in the cycle after the edge that accepts the frame's last response. `frame_start_i` is ignored while a frame is running and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Start-frame pulse, accepted when idle |
| rsp_valid_i | input | 1 | Response to the current slot is present |
| ack_status_i | input | 8 | Acknowledge status byte of the response |
| thresh_i | input | 8 | Drop threshold, 1..128 |
| poll_valid_o | output | 1 | A slot is being offered |
| poll_id_o | output | 3 | Slave to poll in the current slot |
| poll_revive_o | output | 1 | Current slot is the revive slot |
| frame_done_o | output | 1 | Frame finished pulse |
| status_o | output | 8 | Per-slave status bit of the last response |

## Verification
On every cycle the assertions check these properties: a normal slot only targets a slave from the frame-start list, IDs rise within the normal part, a slot holds until it is answered, and the revive slot only targets a slave that was off the list. They also check that a slave leaves the list only after a dummy response and rejoins only after an active one, that counts saturate, and that the done pulse lasts one cycle. Only the bench scenarios can show that the threshold boundary is exact, that the round-robin order across several frames is right, that saturation blocks a wrap of the count, and that a start pulse arriving mid-frame is dropped rather than queued.

// File: rtl/poll_sched_pkg.sv
package poll_sched_pkg;
  localparam int CNT_W   = 7;
  localparam int TH_W    = CNT_W + 1;
  localparam int ACT_BIT = 7;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_NORM = 2'd1,
    ST_REV  = 2'd2,
    ST_DONE = 2'd3
  } sched_st_e;
endpackage

// File: rtl/poll_sched_pick.sv
module poll_sched_pick #(
  parameter int N     = 8,
  parameter bit WRAP  = 1'b0,
  localparam int ID_W = $clog2(N),
  localparam int IX_W = ID_W + 1
) (
  input  logic [N-1:0]    mask_i,
  input  logic [IX_W-1:0] from_i,
  output logic            found_o,
  output logic [ID_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      int unsigned p;
      p = int'(from_i) + k;
      if (WRAP) p = p % N;
      if (p < N && !found_o && mask_i[p]) begin
        found_o = 1'b1;
        idx_o   = ID_W'(p);
      end
    end
  end
endmodule

// File: rtl/poll_sched_node.sv
module poll_sched_node
  import poll_sched_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            upd_i,
  input  logic            active_i,
  input  logic [TH_W-1:0] thresh_i,
  output logic            in_list_o,
  output logic            stat_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             in_list_q, stat_q;

  assign cnt_inc = (cnt_q == CNT_W'(CNT_MAX)) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      in_list_q <= 1'b1;
      stat_q    <= 1'b1;
    end else if (upd_i) begin
      if (active_i) begin
        cnt_q     <= '0;
        stat_q    <= 1'b1;
        in_list_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_inc;
        stat_q <= 1'b0;
        if ({1'b0, cnt_inc} > thresh_i) in_list_q <= 1'b0;
      end
    end
  end

  assign in_list_o = in_list_q;
  assign stat_o    = stat_q;

  assert_drop_after_dummy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_list_q) |-> $past(upd_i && !active_i));
  assert_rejoin_after_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_list_q) |-> $past(upd_i && active_i));
  assert_count_saturates_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !active_i && cnt_q == CNT_W'(CNT_MAX)) |=> cnt_q == CNT_W'(CNT_MAX));
  assert_active_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && active_i) |=> (cnt_q == '0 && stat_q));
endmodule

// File: rtl/poll_sched.sv
module poll_sched
  import poll_sched_pkg::*;
#(
  parameter int NUM_NODES = 8,
  localparam int ID_W     = $clog2(NUM_NODES),
  localparam int IX_W     = ID_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 rsp_valid_i,
  input  logic [7:0]           ack_status_i,
  input  logic [TH_W-1:0]      thresh_i,
  output logic                 poll_valid_o,
  output logic [ID_W-1:0]      poll_id_o,
  output logic                 poll_revive_o,
  output logic                 frame_done_o,
  output logic [NUM_NODES-1:0] status_o
);
  sched_st_e              state_q;
  logic [ID_W-1:0]        cur_q, last_rev_q;
  logic [NUM_NODES-1:0]   snap_q, in_list, list_view;
  logic                   act_found, rev_found, rsp_take;
  logic [ID_W-1:0]        act_idx, rev_idx;
  logic [IX_W-1:0]        act_from, rev_from;

  // in idle the live list is searched so a frame can start without a bubble
  assign list_view = (state_q == ST_IDLE) ? in_list : snap_q;
  assign act_from  = (state_q == ST_IDLE) ? '0 : IX_W'(cur_q) + 1'b1;
  assign rev_from  = IX_W'(last_rev_q) + 1'b1;
  assign rsp_take  = rsp_valid_i && poll_valid_o;

  poll_sched_pick #(.N(NUM_NODES), .WRAP(1'b0)) u_pick_act (
    .mask_i(list_view), .from_i(act_from), .found_o(act_found), .idx_o(act_idx));
  poll_sched_pick #(.N(NUM_NODES), .WRAP(1'b1)) u_pick_rev (
    .mask_i(~list_view), .from_i(rev_from), .found_o(rev_found), .idx_o(rev_idx));

  for (genvar g = 0; g < NUM_NODES; g++) begin : g_node
    poll_sched_node u_node (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (rsp_take && cur_q == ID_W'(g)),
      .active_i (ack_status_i[ACT_BIT]),
      .thresh_i (thresh_i),
      .in_list_o(in_list[g]),
      .stat_o   (status_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_q      <= '0;
      snap_q     <= '1;
      last_rev_q <= ID_W'(NUM_NODES - 1);
    end else begin
      unique case (state_q)
        ST_IDLE: if (frame_start_i) begin
          snap_q <= in_list;
          if (act_found) begin
            state_q <= ST_NORM;
            cur_q   <= act_idx;
          end else if (rev_found) begin
            state_q <= ST_REV;
            cur_q   <= rev_idx;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_NORM: if (rsp_valid_i) begin
          if (act_found) begin
            cur_q <= act_idx;
          end else if (rev_found) begin
            state_q <= ST_REV;
            cur_q   <= rev_idx;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_REV: if (rsp_valid_i) begin
          last_rev_q <= cur_q;
          state_q    <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign poll_valid_o  = (state_q == ST_NORM) || (state_q == ST_REV);
  assign poll_revive_o = (state_q == ST_REV);
  assign poll_id_o     = cur_q;
  assign frame_done_o  = (state_q == ST_DONE);

  assert_norm_member_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_valid_o && !poll_revive_o) |-> snap_q[poll_id_o]);
  assert_ascending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_valid_o && !poll_revive_o && $past(poll_valid_o && !poll_revive_o && rsp_valid_i))
      |-> poll_id_o > $past(poll_id_o));
  assert_slot_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_valid_o && !rsp_valid_i) |=> (poll_valid_o && $stable(poll_id_o) && $stable(poll_revive_o)));
  assert_revive_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_revive_o |-> (poll_valid_o && !snap_q[poll_id_o]));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> (!frame_done_o && !poll_valid_o));
endmodule

// File: tb/tb_poll_sched.sv
module tb_poll_sched;
  localparam int N = 8;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       frame_start_i = 1'b0, rsp_valid_i = 1'b0;
  logic [7:0] ack_status_i = '0, thresh_i = 8'd4;
  logic       poll_valid_o, poll_revive_o, frame_done_o;
  logic [2:0] poll_id_o;
  logic [N-1:0] status_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [N-1:0] m_list = '1, m_st = '1;
  int m_cnt [N];
  int m_last = N - 1;
  logic [N-1:0] seen_norm;

  always #5 clk_i = ~clk_i;

  poll_sched dut (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_rsp(input int id, input bit act);
    if (act) begin
      m_cnt[id] = 0; m_st[id] = 1'b1; m_list[id] = 1'b1;
    end else begin
      if (m_cnt[id] < 127) m_cnt[id]++;
      m_st[id] = 1'b0;
      if (m_cnt[id] > int'(thresh_i)) m_list[id] = 1'b0;
    end
  endtask

  task automatic slot(input int id, input bit rev, input bit act, input bit stray_start, input string req);
    chk(poll_valid_o === 1'b1, {req, " slot valid"}, int'(poll_valid_o), 1);
    chk(int'(poll_id_o) == id, {req, " slot id"}, int'(poll_id_o), id);
    chk(poll_revive_o === rev, {req, " revive flag"}, int'(poll_revive_o), int'(rev));
    if (!rev) seen_norm[poll_id_o] = 1'b1;
    rsp_valid_i   = 1'b1;
    ack_status_i  = act ? 8'h95 : 8'h7F;  // R2 low bits carry noise
    frame_start_i = stray_start;
    @(negedge clk_i);
    rsp_valid_i   = 1'b0;
    frame_start_i = 1'b0;
    model_rsp(id, act);
  endtask

  // pat bit per slave: 1 = active response, 0 = dummy
  task automatic frame(input logic [N-1:0] pat, input bit stray_start);
    logic [N-1:0] snap = m_list;
    bool_first: begin end
    seen_norm = '0;
    frame_start_i = 1'b1;
    @(negedge clk_i);
    frame_start_i = 1'b0;
    for (int i = 0; i < N; i++)
      if (snap[i]) slot(i, 1'b0, pat[i], stray_start && i == 0, "R4");
    if (~snap != '0) begin
      int r = -1;
      for (int k = 1; k <= N; k++)
        if (r < 0 && !snap[(m_last + k) % N]) r = (m_last + k) % N;
      slot(r, 1'b1, pat[r], 1'b0, "R5");
      m_last = r;
    end
    chk(frame_done_o === 1'b1 && poll_valid_o === 1'b0, "R8 done after last response",
        int'(frame_done_o), 1);
    @(negedge clk_i);
    chk(frame_done_o === 1'b0, "R8 done one cycle", int'(frame_done_o), 0);
    chk(status_o === m_st, "R2 status bits", int'(status_o), int'(m_st));
  endtask

  task automatic t_reset_and_full;
    chk(poll_valid_o === 1'b0 && frame_done_o === 1'b0, "R1 idle after reset", int'(poll_valid_o), 0);
    chk(status_o === '1, "R1 status after reset", int'(status_o), 255);
    frame('1, 1'b0);  // all polled 0..7, no revive slot (R6)
    chk(seen_norm === '1, "R6 full list frame", int'(seen_norm), 255);
  endtask

  task automatic t_drop_and_revive;
    thresh_i = 8'd2;
    frame(8'hF7, 1'b0);
    frame(8'hF7, 1'b0);
    chk(seen_norm[3] === 1'b1, "R3 count equal to thresh keeps slave", 0, 1);
    frame(8'hF7, 1'b0);          // count 3 > 2: dropped
    frame(8'hF7, 1'b0);          // revive slot polls 3, dummy
    chk(seen_norm[3] === 1'b0, "R3 dropped slave skipped", int'(seen_norm[3]), 0);
    frame(8'hFF, 1'b0);          // still dropped (R7), revived with active
    chk(seen_norm[3] === 1'b0, "R7 dummy revive stays out", int'(seen_norm[3]), 0);
    frame(8'hFF, 1'b0);
    chk(seen_norm[3] === 1'b1, "R7 rejoined after active revive", int'(seen_norm[3]), 1);
  endtask

  task automatic t_round_robin;
    thresh_i = 8'd1;
    frame(8'h9D, 1'b0);
    frame(8'h9D, 1'b0);          // slaves 1,5,6 dropped
    for (int f = 0; f < 5; f++) frame(8'h9D, 1'b0);  // revive order checked by slot()
    chk(seen_norm[1] === 1'b0 && seen_norm[5] === 1'b0, "R5 dropped set stays out", int'(seen_norm), 8'h9D);
    for (int f = 0; f < 3; f++) frame(8'hFF, 1'b0);  // each revives and rejoins
    frame(8'hFF, 1'b0);
    chk(seen_norm === '1, "R7 all rejoined", int'(seen_norm), 255);
  endtask

  task automatic t_saturate;
    thresh_i = 8'd128;
    for (int f = 0; f < 130; f++) frame(8'hFE, 1'b0);
    chk(seen_norm[0] === 1'b1, "R3 thresh 128 never drops", int'(seen_norm[0]), 1);
    thresh_i = 8'd126;
    frame(8'hFE, 1'b0);          // saturated 127 > 126
    frame(8'hFF, 1'b0);
    chk(seen_norm[0] === 1'b0, "R2 count saturated not wrapped", int'(seen_norm[0]), 0);
    frame(8'hFF, 1'b0);
  endtask

  task automatic t_stray_start;
    frame(8'hFF, 1'b1);
    repeat (3) begin
      chk(poll_valid_o === 1'b0 && frame_done_o === 1'b0, "R8 mid-frame start not queued",
          int'(poll_valid_o), 0);
      @(negedge clk_i);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_and_full();
    t_drop_and_revive();
    t_round_robin();
    t_saturate();
    t_stray_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule